// File: doc/BRIEF.md
# March Self-Test Sequencer for a One-Bit RAM

This block runs a three-pass march test on a synchronous RAM that stores one bit per address. While a run is active it takes over the RAM's address, write-data and write-enable lines from the functional logic through a select stage. The first pass clears every cell. The second pass walks upward, checking for a 0 and leaving a 1 behind. The third pass walks the same addresses in exactly the opposite order, checking for a 1 and leaving a 0 behind. Every read is compared with the value the algorithm expects. A run stops on the first wrong value and reports failure. A run with no wrong value reports success.

Addresses are not produced by a binary counter. They come from a shift register with linear feedback that can shift in either direction. A zero-detect term in its feedback adds the all-zero state to its cycle, so one sweep covers all 2^ADDR_W cells. Shifting the other way replays that sweep backwards. A pulse on the start input launches a run. Outside a run the functional port reaches the RAM unchanged.

Top module: `march_bist_ctrl`

## Requirements
- R1: While reset is held low, and after reset until the first start, done, pass and fail are all 0.
- R2: Whenever no run is active (before the first start, and after done is set), ram_addr, ram_we and ram_wdata equal sys_addr, sys_we and sys_wdata in the same cycle.
- R3: In the cycle after start is sampled, the RAM sees no write. This is a seed cycle. In the following 2^ADDR_W cycles the RAM sees one write of 0 per cycle, and the first of these writes goes to address 0.
- R4: After the clearing pass, each address in the ascending order gets two cycles. The first cycle is a read (ram_we=0). In the second cycle, the same address receives a write of 1. The data returned by the read must be 0.
- R5: After the upward pass, the addresses are visited in the exact reverse of the ascending order. Each address gets a read cycle and then a write of 0 to the same address. The data returned by the read must be 1.
- R6: The ascending order visits each of the 2^ADDR_W addresses exactly once. It starts at address 0 and ends at the address whose most significant bit is 1 and all other bits are 0. Successive steps never repeat an address.
- R7: With a fault-free RAM, done rises 5*2^ADDR_W+1 clock cycles after the cycle in which start is sampled.
- R8: At the end of a run with no mismatch, done=1, pass=1 and fail=0. These values hold until the next start.
- R9: The first read that returns the wrong value ends the run. In the cycle where the mismatched data is compared, ram_we is 0. From the next cycle on, done=1, fail=1 and pass=0, and these values hold until the next start. A stuck-at-0 cell, a stuck-at-1 cell, and an address that decodes onto another cell are each reported this way.
- R10: A start received after done is set begins a new run, and done, pass and fail clear in the cycle that follows.
- R11: A start pulse during an active run has no effect on the access sequence or on the run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a test run when the block is idle or finished |
| sys_addr | input | ADDR_W | Functional address, forwarded to the RAM when no run is active |
| sys_we | input | 1 | Functional write enable |
| sys_wdata | input | 1 | Functional write data |
| ram_addr | output | ADDR_W | Address to the RAM |
| ram_we | output | 1 | Write enable to the RAM |
| ram_wdata | output | 1 | Write data to the RAM |
| ram_rdata | input | 1 | RAM read data, valid one cycle after the address |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Finished on a mismatch |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 cells. At that size every cell can be given a stuck-at-0 fault, then a stuck-at-1 fault, and then an aliasing fault in which it decodes onto its neighbour. For each fault, the bench predicts the exact cycle of failure from the cell's position in the observed upward order. A fault-free run is recorded access by access, so the bench can confirm the full permutation, the exact reversal, the read-then-write pairs and the 81-cycle run length.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

   localparam int MAX_ADDR_W = 8;
   localparam int NUM_ELEMENTS = 3;

   typedef enum logic [3:0] {
      ST_START,
      ST_M0_SEED,
      ST_M0_WR,
      ST_M1_RD,
      ST_M1_WR,
      ST_M2_RD,
      ST_M2_WR,
      ST_ERROR,
      ST_CORRECT
   } march_state_e;

   // Feedback masks for maximal-length shift registers; bit w-1 always set.
   function automatic logic [MAX_ADDR_W-1:0] walker_taps(input int w);
      case (w)
         2: return 8'b0000_0011;
         3: return 8'b0000_0110;
         4: return 8'b0000_1100;
         5: return 8'b0001_0100;
         6: return 8'b0011_0000;
         7: return 8'b0110_0000;
         default: return 8'b1011_1000;
      endcase
   endfunction

endpackage

// File: rtl/march_addr_walker.sv
module march_addr_walker
   import march_bist_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              dir_down,
   input  logic [ADDR_W-1:0] seed,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [MAX_ADDR_W-1:0] TAPS_FULL = walker_taps(ADDR_W);
   localparam logic [ADDR_W-1:0]     TAPS      = TAPS_FULL[ADDR_W-1:0];

   logic [ADDR_W-1:0] q;
   logic [ADDR_W-1:0] nxt;
   logic              fb_up;
   logic              fb_dn;

   // Zero-detect on the stages that survive the shift inserts the all-zero state.
   assign fb_up = (^(q & TAPS)) ^ ~(|q[ADDR_W-2:0]);
   assign fb_dn = q[0] ^ (^(q[ADDR_W-1:1] & TAPS[ADDR_W-2:0])) ^ ~(|q[ADDR_W-1:1]);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_stage
      logic from_up;
      logic from_dn;
      if (i == 0) begin : g_low
         assign from_up = fb_up;
      end else begin : g_mid_up
         assign from_up = q[i-1];
      end
      if (i == ADDR_W - 1) begin : g_high
         assign from_dn = fb_dn;
      end else begin : g_mid_dn
         assign from_dn = q[i+1];
      end
      assign nxt[i] = dir_down ? from_dn : from_up;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= seed;
      else if (step) q <= nxt;
   end

   assign addr = q;

   AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr != $past(addr))); // R6

endmodule

// File: rtl/march_port_mux.sv
module march_port_mux #(
   parameter int ADDR_W = 6
) (
   input  logic              bist_sel,
   input  logic [ADDR_W-1:0] bist_addr,
   input  logic              bist_we,
   input  logic              bist_wdata,
   input  logic [ADDR_W-1:0] sys_addr,
   input  logic              sys_we,
   input  logic              sys_wdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_we,
   output logic              ram_wdata
);
   always_comb begin
      if (bist_sel) begin
         ram_addr  = bist_addr;
         ram_we    = bist_we;
         ram_wdata = bist_wdata;
      end else begin
         ram_addr  = sys_addr;
         ram_we    = sys_we;
         ram_wdata = sys_wdata;
      end
   end
endmodule

// File: rtl/march_seq.sv
module march_seq
   import march_bist_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rdata,
   output logic              walk_load,
   output logic              walk_step,
   output logic              walk_down,
   output logic [ADDR_W-1:0] walk_seed,
   output logic              bist_sel,
   output logic              bist_we,
   output logic              bist_wdata,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   localparam logic [ADDR_W-1:0] FIRST_UP = '0;
   localparam logic [ADDR_W-1:0] LAST_UP  = {1'b1, {(ADDR_W-1){1'b0}}};

   march_state_e state_q, state_d;

   always_comb begin
      state_d    = state_q;
      walk_load  = 1'b0;
      walk_step  = 1'b0;
      walk_down  = 1'b0;
      walk_seed  = FIRST_UP;
      bist_we    = 1'b0;
      bist_wdata = 1'b0;
      case (state_q)
         ST_START, ST_ERROR, ST_CORRECT: begin
            if (start) state_d = ST_M0_SEED;
         end
         ST_M0_SEED: begin
            walk_load = 1'b1;
            state_d   = ST_M0_WR;
         end
         ST_M0_WR: begin
            bist_we = 1'b1;
            if (addr == LAST_UP) begin
               walk_load = 1'b1;
               state_d   = ST_M1_RD;
            end else begin
               walk_step = 1'b1;
            end
         end
         ST_M1_RD: state_d = ST_M1_WR;
         ST_M1_WR: begin
            if (rdata != 1'b0) begin
               state_d = ST_ERROR;
            end else begin
               bist_we    = 1'b1;
               bist_wdata = 1'b1;
               if (addr == LAST_UP) begin
                  walk_load = 1'b1;
                  walk_seed = LAST_UP;
                  state_d   = ST_M2_RD;
               end else begin
                  walk_step = 1'b1;
                  state_d   = ST_M1_RD;
               end
            end
         end
         ST_M2_RD: begin
            walk_down = 1'b1;
            state_d   = ST_M2_WR;
         end
         ST_M2_WR: begin
            walk_down = 1'b1;
            if (rdata != 1'b1) begin
               state_d = ST_ERROR;
            end else begin
               bist_we = 1'b1;
               if (addr == FIRST_UP) begin
                  state_d = ST_CORRECT;
               end else begin
                  walk_step = 1'b1;
                  state_d   = ST_M2_RD;
               end
            end
         end
         default: state_d = ST_START;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_START;
      else        state_q <= state_d;
   end

   assign bist_sel = !(state_q inside {ST_START, ST_ERROR, ST_CORRECT});
   assign done     = (state_q == ST_ERROR) || (state_q == ST_CORRECT);
   assign pass     = (state_q == ST_CORRECT);
   assign fail     = (state_q == ST_ERROR);

   AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass ^ fail)); // R8

   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail); // R9

   AST_RD_WR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_M1_WR || state_q == ST_M2_WR) |-> $stable(addr)); // R4

   AST_M0_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_M0_WR && $past(state_q) == ST_M0_SEED) |-> (addr == FIRST_UP)); // R3

endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
   import march_bist_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] sys_addr,
   input  logic              sys_we,
   input  logic              sys_wdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_we,
   output logic              ram_wdata,
   input  logic              ram_rdata,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   if (ADDR_W < 2 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
      $error("march_bist_ctrl: ADDR_W must lie in 2..%0d", MAX_ADDR_W);
   end

   logic              walk_load;
   logic              walk_step;
   logic              walk_down;
   logic [ADDR_W-1:0] walk_seed;
   logic [ADDR_W-1:0] walk_addr;
   logic              bist_sel;
   logic              bist_we;
   logic              bist_wdata;

   march_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .addr       (walk_addr),
      .rdata      (ram_rdata),
      .walk_load  (walk_load),
      .walk_step  (walk_step),
      .walk_down  (walk_down),
      .walk_seed  (walk_seed),
      .bist_sel   (bist_sel),
      .bist_we    (bist_we),
      .bist_wdata (bist_wdata),
      .done       (done),
      .pass       (pass),
      .fail       (fail)
   );

   march_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (walk_load),
      .step     (walk_step),
      .dir_down (walk_down),
      .seed     (walk_seed),
      .addr     (walk_addr)
   );

   march_port_mux #(.ADDR_W(ADDR_W)) u_mux (
      .bist_sel   (bist_sel),
      .bist_addr  (walk_addr),
      .bist_we    (bist_we),
      .bist_wdata (bist_wdata),
      .sys_addr   (sys_addr),
      .sys_we     (sys_we),
      .sys_wdata  (sys_wdata),
      .ram_addr   (ram_addr),
      .ram_we     (ram_we),
      .ram_wdata  (ram_wdata)
   );

endmodule

// File: tb/march_bist_ctrl_bench.sv
`timescale 1ns/1ps
module march_bist_ctrl_bench;
   localparam int AW  = 4;
   localparam int N   = 1 << AW;
   localparam int TRL = 5 * N + 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [AW-1:0] sys_addr;
   logic          sys_we;
   logic          sys_wdata;
   logic [AW-1:0] ram_addr;
   logic          ram_we;
   logic          ram_wdata;
   logic          ram_rdata;
   logic          done, pass, fail;

   always #10 clk = ~clk;

   march_bist_ctrl #(.ADDR_W(AW)) u_march_bist_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .sys_addr(sys_addr), .sys_we(sys_we), .sys_wdata(sys_wdata),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .done(done), .pass(pass), .fail(fail)
   );

   // RAM model: 0 none, 1 stuck-at-0, 2 stuck-at-1, 3 address fa decodes onto fb
   int            fk;
   logic [AW-1:0] fa, fb;
   logic          mem [N];

   function automatic logic [AW-1:0] eff(input logic [AW-1:0] a);
      return (fk == 3 && a == fa) ? fb : a;
   endfunction

   function automatic logic rd_val(input logic [AW-1:0] e);
      if (fk == 1 && e == fa) return 1'b0;
      if (fk == 2 && e == fa) return 1'b1;
      return mem[e];
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem[i] <= 1'b1;
         ram_rdata <= 1'b0;
      end else begin
         if (ram_we) mem[eff(ram_addr)] <= ram_wdata;
         ram_rdata <= rd_val(eff(ram_addr));
      end
   end

   int nchk = 0;
   int nerr = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   logic          t_we [TRL];
   logic [AW-1:0] t_ad [TRL];
   logic          t_wd [TRL];
   logic          t_dn [TRL];
   logic          t_ps [TRL];
   logic          t_fl [TRL];
   int            tlen;
   int            up [N];

   task automatic run(input int kind, input int a, input int b, input int mid);
      fk = kind; fa = AW'(a); fb = AW'(b);
      @(negedge clk) start = 1'b1;
      @(negedge clk);
      tlen = TRL;
      for (int i = 0; i < TRL; i++) begin
         t_we[i] = ram_we; t_ad[i] = ram_addr; t_wd[i] = ram_wdata;
         t_dn[i] = done;   t_ps[i] = pass;     t_fl[i] = fail;
         start = (i == mid);
         if (done) begin
            tlen = i + 1;
            break;
         end
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   function automatic int pos_of(input int c);
      for (int k = 0; k < N; k++) if (up[k] == c) return k;
      return -1;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      int bad;
      bit seen [N];
      rst_n = 1'b0; start = 1'b0; fk = 0; fa = '0; fb = '0;
      sys_addr = AW'(5); sys_we = 1'b1; sys_wdata = 1'b1;
      repeat (3) @(negedge clk);
      chk(!done && !pass && !fail, "R1 status in reset", {done, pass, fail}, 0);
      chk(ram_addr == AW'(5) && ram_we && ram_wdata, "R2 pass-through in reset", ram_addr, 5);
      rst_n = 1'b1;
      @(negedge clk);
      sys_addr = AW'(9); sys_we = 1'b0; sys_wdata = 1'b0;
      @(negedge clk);
      chk(!done && !pass && !fail, "R1 status after reset", {done, pass, fail}, 0);
      chk(ram_addr == AW'(9) && !ram_we && !ram_wdata, "R2 pass-through idle", ram_addr, 9);

      // fault-free run, recorded access by access
      run(0, 0, 0, -1);
      chk(tlen == 5 * N + 2, "R7 run length", tlen - 1, 5 * N + 1);
      chk(t_dn[tlen-1] && t_ps[tlen-1] && !t_fl[tlen-1], "R8 pass status",
          {t_dn[tlen-1], t_ps[tlen-1], t_fl[tlen-1]}, 6);
      chk(!t_we[0], "R3 seed cycle has no write", t_we[0], 0);
      bad = 0;
      for (int k = 0; k < N; k++) begin
         if (!t_we[1+k] || t_wd[1+k]) bad++;
         up[k] = int'(t_ad[1+k]);
      end
      chk(bad == 0, "R3 clearing writes", bad, 0);
      chk(up[0] == 0, "R3 clearing starts at 0", up[0], 0);
      chk(up[0] == 0 && up[N-1] == N / 2, "R6 order end points", up[N-1], N / 2);
      bad = 0;
      for (int k = 0; k < N; k++) seen[k] = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (seen[up[k]]) bad++;
         seen[up[k]] = 1'b1;
      end
      chk(bad == 0, "R6 every address once", bad, 0);
      bad = 0;
      for (int k = 0; k < N; k++) begin
         if (t_we[N+1+2*k] || int'(t_ad[N+1+2*k]) != up[k]) bad++;
         if (!t_we[N+2+2*k] || !t_wd[N+2+2*k] || int'(t_ad[N+2+2*k]) != up[k]) bad++;
      end
      chk(bad == 0, "R4 upward read-then-write-1", bad, 0);
      bad = 0;
      for (int k = 0; k < N; k++) begin
         if (t_we[3*N+1+2*k] || int'(t_ad[3*N+1+2*k]) != up[N-1-k]) bad++;
         if (!t_we[3*N+2+2*k] || t_wd[3*N+2+2*k] || int'(t_ad[3*N+2+2*k]) != up[N-1-k]) bad++;
      end
      chk(bad == 0, "R5 reversed read-then-write-0", bad, 0);

      sys_addr = AW'(3); sys_we = 1'b1; sys_wdata = 1'b0;
      repeat (3) @(negedge clk);
      chk(ram_addr == AW'(3) && ram_we && !ram_wdata, "R2 pass-through after done", ram_addr, 3);
      chk(done && pass && !fail, "R8 status held", {done, pass, fail}, 6);
      sys_we = 1'b0;

      // start pulse during the run is ignored
      run(0, 0, 0, 20);
      chk(!t_dn[0] && !t_ps[0], "R10 restart clears status", t_dn[0], 0);
      chk(tlen == 5 * N + 2 && t_ps[tlen-1], "R11 mid-run start ignored", tlen - 1, 5 * N + 1);

      // stuck-at-1 on every cell: caught in the upward pass
      bad = 0;
      for (int c = 0; c < N; c++) begin
         int p;
         p = pos_of(c);
         run(2, c, 0, -1);
         if (tlen != N + 4 + 2 * p || !t_fl[tlen-1] || t_ps[tlen-1] || t_we[N+2+2*p]) begin
            bad++;
            $display("  SA1 cell %0d: len=%0d exp=%0d", c, tlen, N + 4 + 2 * p);
         end
      end
      chk(bad == 0, "R9 stuck-at-1 sweep", bad, 0);

      // stuck-at-0 on every cell: caught in the downward pass
      bad = 0;
      for (int c = 0; c < N; c++) begin
         int q;
         q = N - 1 - pos_of(c);
         run(1, c, 0, -1);
         if (tlen != 3 * N + 4 + 2 * q || !t_fl[tlen-1] || t_ps[tlen-1] || t_we[3*N+2+2*q]) begin
            bad++;
            $display("  SA0 cell %0d: len=%0d exp=%0d", c, tlen, 3 * N + 4 + 2 * q);
         end
      end
      chk(bad == 0, "R9 stuck-at-0 sweep", bad, 0);

      // address c decodes onto cell c+1
      bad = 0;
      for (int c = 0; c < N; c++) begin
         int pa, pb, pm;
         pa = pos_of(c);
         pb = pos_of((c + 1) % N);
         pm = (pa > pb) ? pa : pb;
         run(3, c, (c + 1) % N, -1);
         if (c == 0 && t_dn[0]) bad++;
         if (tlen != N + 4 + 2 * pm || !t_fl[tlen-1] || t_ps[tlen-1]) begin
            bad++;
            $display("  alias %0d: len=%0d exp=%0d", c, tlen, N + 4 + 2 * pm);
         end
      end
      chk(bad == 0, "R9 aliasing sweep", bad, 0);
      @(negedge clk);
      chk(done && fail && !pass, "R9 fail held", {done, pass, fail}, 5);

      // a final clean run after failures still passes
      run(0, 0, 0, -1);
      chk(!t_dn[0] && tlen == 5 * N + 2 && t_ps[tlen-1], "R10 clean run after fail", tlen - 1, 5 * N + 1);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule